// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block produces the frequency offset word that steers a fractional-N feedback divider, so that a synthesized clock sweeps around, or just below, its nominal frequency and spreads its energy over a band. The word is a signed fraction of the nominal frequency. It is recomputed on every sample tick and comes with a one-cycle valid strobe. All spread outputs that share the generator see the same setting. The PLL, the oscillator and the divider itself lie outside the block.

The waveform is a symmetric triangle that a phase accumulator builds up. The accumulator steps once per sample tick, and the size of each step comes from one of four modulation rates. Two sweep shapes are available. Center mode swings evenly above and below nominal. Down mode sweeps from nominal down to a programmable minimum and back, and it has twice the magnitude range. An active-low enable input stops the sweep and pins the offset to zero. Mode, magnitude and rate are taken into use only where the triangle passes through zero offset, so a new setting never makes the output jump.

Top module: `sscModGen`

## Requirements
- R1: In center mode (modeDown=0), with k = min(spreadCode,19)+1, the peak is P=(k*65536+400)/800 (integer division), which gives 0.125% to 2.5% of nominal. The offset is P*r/16384 with the sign applied after truncation. For a phase p (16 bits) in quadrant q=p[15:14], r is p[13:0] when q is even and 16384-p[13:0] when q is odd. The sign is negative when q[1]=1.
- R2: In down mode (modeDown=1), the minimum is D=(k*65536+200)/400, which gives -0.25% to -5.0%. The offset is -(D*u/32768), where u=p when p<32768 and u=65536-p otherwise. The offset is never positive.
- R3: The phase step per tick is round(f*65536/SAMPLE_KHZ) for f = 31.5, 60, 90 or 120 kHz, selected by rateSel 0 to 3. The default sample rate is 2016 kHz, so rateSel 0 gives a period of exactly 64 ticks. When a step would carry past 65535, the phase becomes 0 instead.
- R4: A tick taken while spreadOffN=1 sets the offset to exactly 0, and the offset stays 0 until the sweep is enabled again.
- R5: The first tick taken with spreadOffN=0 after a disabled period produces offset 0. The sweep then proceeds from phase 0, so the following sample is positive in center mode and negative in down mode.
- R6: modeDown, spreadCode and rateSel are taken into use only on ticks where the phase returns to 0: at a wrap, while disabled, or on the restart tick. Changes made at any other time have no effect on the offset until then.
- R7: spreadCode values from 20 to 31 behave exactly like 19.
- R8: offsetValid is high for exactly the one cycle after each tick. Without a tick, offset holds its value.
- R9: After reset, offset is 0 and offsetValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleTick | input | 1 | One-cycle pulse that advances the waveform |
| spreadOffN | input | 1 | High: spread off, offset held at zero |
| modeDown | input | 1 | 0: center sweep, 1: down sweep |
| spreadCode | input | 5 | Spread magnitude code, saturating at 19 |
| rateSel | input | 2 | Modulation rate select |
| offset | output | 16 | Signed offset in units of 1/65536 of nominal |
| offsetValid | output | 1 | Strobe that marks a new offset sample |

## Verification
The hardest situation to reach from the ports is a change of setting in the middle of a sweep. It has to stay invisible until the triangle wraps, and then it has to take effect at exactly the zero sample. The stimulus starts a center sweep and changes mode, magnitude and rate ten ticks into the period. It then runs the sweep past the wrap and compares every sample with a model that takes the new values only when the phase returns to zero. The rate tests use step sizes that do not divide the phase range, which exercises the clamp at the wrap, and a saturated code is checked at the exact quarter-period peak.

// File: rtl/sscModPkg.sv
package sscModPkg;
  localparam int SSC_CODE_W = 5;
  localparam int SSC_RATES  = 4;
  // Modulation rates in units of 0.1 kHz, indexed by the rate select code
  localparam int RATE_X10 [SSC_RATES] = '{315, 600, 900, 1200};

  typedef struct packed {
    logic down;
    logic [SSC_CODE_W-1:0] code;
    logic [1:0] rate;
  } sscCfg_t;

  typedef struct packed {
    logic clearPhase;
    logic advance;
    logic latchCfg;
    logic forceZero;
  } sscCtl_t;
endpackage

// File: rtl/sscModCtl.sv
module sscModCtl
  import sscModPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sampleTick,
  input  logic    spreadOffN,
  input  logic    wrapNext,
  output sscCtl_t ctl,
  output logic    offsetValid
);
  logic activeQ;
  logic restartNow;

  assign restartNow     = spreadOffN | ~activeQ | wrapNext;
  assign ctl.clearPhase = sampleTick & restartNow;
  assign ctl.latchCfg   = sampleTick & restartNow;
  assign ctl.advance    = sampleTick & ~restartNow;
  assign ctl.forceZero  = ~activeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      activeQ     <= 1'b0;
      offsetValid <= 1'b0;
    end else begin
      offsetValid <= sampleTick;
      if (sampleTick) activeQ <= ~spreadOffN;
    end
  end

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    sampleTick |=> offsetValid); // R8
  AST_NO_VALID_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    !sampleTick |=> !offsetValid); // R8
endmodule

// File: rtl/sscModDp.sv
module sscModDp
  import sscModPkg::*;
#(
  parameter int PHASE_W        = 16,
  parameter int OUT_W          = 16,
  parameter int MAX_CODE       = 19,
  parameter int SAMPLE_KHZ_X10 = 20160
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sscCtl_t                 ctl,
  input  logic                    modeDown,
  input  logic [SSC_CODE_W-1:0]   spreadCode,
  input  logic [1:0]              rateSel,
  output logic                    wrapNext,
  output logic signed [OUT_W-1:0] offset
);
  localparam int  QW       = PHASE_W - 2;
  localparam longint QUARTER = longint'(1) << QW;
  localparam longint FULLPH  = longint'(1) << PHASE_W;
  localparam longint UNITS   = longint'(1) << OUT_W;

  logic [PHASE_W-1:0] incTable [SSC_RATES];
  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W:0]   phaseSum;
  sscCfg_t            cfgQ;

  for (genvar g = 0; g < SSC_RATES; g++) begin : gRate
    assign incTable[g] = PHASE_W'((longint'(RATE_X10[g]) * FULLPH
                                   + longint'(SAMPLE_KHZ_X10 / 2)) / longint'(SAMPLE_KHZ_X10));
  end

  function automatic longint peakOf(input logic down, input logic [SSC_CODE_W-1:0] code);
    longint k;
    k = (int'(code) > MAX_CODE) ? longint'(MAX_CODE + 1) : longint'(code) + 1;
    return down ? (k * UNITS + 200) / 400 : (k * UNITS + 400) / 800;
  endfunction

  assign phaseSum = {1'b0, phaseQ} + {1'b0, incTable[cfgQ.rate]};
  assign wrapNext = phaseSum[PHASE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= '0;
      cfgQ   <= '0;
    end else begin
      if (ctl.clearPhase)   phaseQ <= '0;
      else if (ctl.advance) phaseQ <= phaseSum[PHASE_W-1:0];
      if (ctl.latchCfg)     cfgQ   <= '{down: modeDown, code: spreadCode, rate: rateSel};
    end
  end

  logic [1:0]  quad;
  longint      peak;
  longint      ramp;
  longint      mag;
  longint      value;

  always_comb begin
    quad = phaseQ[PHASE_W-1 -: 2];
    peak = peakOf(cfgQ.down, cfgQ.code);
    if (cfgQ.down) begin
      ramp  = phaseQ[PHASE_W-1] ? FULLPH - longint'(phaseQ) : longint'(phaseQ);
      mag   = (peak * ramp) >>> (PHASE_W - 1);
      value = -mag;
    end else begin
      ramp  = quad[0] ? QUARTER - longint'(phaseQ[QW-1:0]) : longint'(phaseQ[QW-1:0]);
      mag   = (peak * ramp) >>> QW;
      value = quad[1] ? -mag : mag;
    end
    if (ctl.forceZero) value = 0;
  end

  assign offset = OUT_W'(value);

  AST_DOWN_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
    cfgQ.down |-> (offset <= 0)); // R2
  AST_CENTER_BOUND: assert property (@(posedge clk) disable iff (rst)
    !cfgQ.down |-> (longint'(offset) <= peak && longint'(offset) >= -peak)); // R1
  AST_CFG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfgQ) |-> (phaseQ == '0)); // R6
endmodule

// File: rtl/sscModGen.sv
module sscModGen
  import sscModPkg::*;
#(
  parameter int PHASE_W        = 16,
  parameter int OUT_W          = 16,
  parameter int MAX_CODE       = 19,
  parameter int SAMPLE_KHZ_X10 = 20160
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sampleTick,
  input  logic                    spreadOffN,
  input  logic                    modeDown,
  input  logic [SSC_CODE_W-1:0]   spreadCode,
  input  logic [1:0]              rateSel,
  output logic signed [OUT_W-1:0] offset,
  output logic                    offsetValid
);
  sscCtl_t ctl;
  logic    wrapNext;

  sscModCtl i_ctl (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .spreadOffN(spreadOffN),
    .wrapNext(wrapNext), .ctl(ctl), .offsetValid(offsetValid)
  );

  sscModDp #(
    .PHASE_W(PHASE_W), .OUT_W(OUT_W), .MAX_CODE(MAX_CODE), .SAMPLE_KHZ_X10(SAMPLE_KHZ_X10)
  ) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .modeDown(modeDown), .spreadCode(spreadCode),
    .rateSel(rateSel), .wrapNext(wrapNext), .offset(offset)
  );

  AST_OFF_GIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sampleTick && spreadOffN) |=> (offset == '0)); // R4
endmodule

// File: tb/test_sscModGen.sv
module test_sscModGen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleTick = 1'b0;
  logic spreadOffN = 1'b1;
  logic modeDown = 1'b0;
  logic [4:0] spreadCode = '0;
  logic [1:0] rateSel = '0;
  logic signed [15:0] offset;
  logic offsetValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // bench model state
  int mPhase = 0;
  bit mActive = 0;
  bit mDown = 0;
  int mCode = 0;
  int mRate = 0;

  always #4 clk = ~clk;

  sscModGen i_sscModGen (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .spreadOffN(spreadOffN),
    .modeDown(modeDown), .spreadCode(spreadCode), .rateSel(rateSel),
    .offset(offset), .offsetValid(offsetValid)
  );

  function automatic int stepFor(int r);
    int rx10 [4] = '{315, 600, 900, 1200};
    return (rx10[r] * 65536 + 10080) / 20160;
  endfunction

  function automatic int expOff();
    int k, pk, u, f, r;
    if (!mActive) return 0;
    k = ((mCode > 19) ? 19 : mCode) + 1;
    if (mDown) begin
      pk = (k * 65536 + 200) / 400;
      u = (mPhase < 32768) ? mPhase : 65536 - mPhase;
      return -((pk * u) / 32768);
    end
    pk = (k * 65536 + 400) / 800;
    f = mPhase % 16384;
    r = ((mPhase / 16384) % 2 == 1) ? 16384 - f : f;
    return (mPhase >= 32768) ? -((pk * r) / 16384) : (pk * r) / 16384;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic latchModel();
    mDown = modeDown; mCode = spreadCode; mRate = rateSel;
  endtask

  task automatic doTick(input string req);
    @(negedge clk) sampleTick = 1'b1;
    if (spreadOffN) begin mPhase = 0; mActive = 0; latchModel(); end
    else if (!mActive) begin mPhase = 0; mActive = 1; latchModel(); end
    else if (mPhase + stepFor(mRate) > 65535) begin mPhase = 0; latchModel(); end
    else mPhase = mPhase + stepFor(mRate);
    @(negedge clk) sampleTick = 1'b0;
    check(offsetValid === 1'b1, req, int'(offsetValid), 1);
    check(int'(offset) == expOff(), req, int'(offset), expOff());
  endtask

  task automatic startSweep(input bit dn, input int code, input int rate);
    spreadOffN = 1'b1;
    doTick("R4");
    modeDown = dn; spreadCode = 5'(code); rateSel = 2'(rate);
    spreadOffN = 1'b0;
  endtask

  task automatic testReset();
    check(offsetValid === 1'b0, "R9", int'(offsetValid), 0);
    check(offset === 16'sd0, "R9", int'(offset), 0);
  endtask

  task automatic testCenter();
    startSweep(1'b0, 7, 0);
    for (int i = 0; i < 70; i++) doTick("R1");
    // phase 16384 reached at tick 16 of a new period
    startSweep(1'b0, 7, 0);
    for (int i = 0; i < 17; i++) doTick("R1");
    check(int'(offset) == 655, "R1", int'(offset), 655);
  endtask

  task automatic testDown();
    startSweep(1'b1, 19, 1);
    for (int i = 0; i < 70; i++) begin
      doTick("R2");
      check(offset <= 0, "R2", int'(offset), 0);
    end
    startSweep(1'b1, 19, 0);
    for (int i = 0; i < 33; i++) doTick("R2");
    check(int'(offset) == -3277, "R2", int'(offset), -3277);
  endtask

  task automatic testRates();
    startSweep(1'b0, 12, 2);
    for (int i = 0; i < 40; i++) doTick("R3");
    startSweep(1'b1, 3, 3);
    for (int i = 0; i < 40; i++) doTick("R3");
    // rate 0: back at zero exactly 64 ticks after the start sample
    startSweep(1'b0, 10, 0);
    for (int i = 0; i < 65; i++) doTick("R3");
    check(int'(offset) == 0, "R3", int'(offset), 0);
  endtask

  task automatic testSaturate();
    startSweep(1'b0, 31, 0);
    for (int i = 0; i < 17; i++) doTick("R7");
    check(int'(offset) == 1638, "R7", int'(offset), 1638);
    startSweep(1'b1, 25, 0);
    for (int i = 0; i < 33; i++) doTick("R7");
    check(int'(offset) == -3277, "R7", int'(offset), -3277);
  endtask

  task automatic testLatch();
    startSweep(1'b0, 4, 0);
    for (int i = 0; i < 10; i++) doTick("R6");
    modeDown = 1'b1; spreadCode = 5'd15; rateSel = 2'd1;
    for (int i = 0; i < 60; i++) doTick("R6");
    check(mDown == 1'b1, "R6", int'(mDown), 1);
    for (int i = 0; i < 20; i++) doTick("R6");
  endtask

  task automatic testDisable();
    startSweep(1'b0, 9, 0);
    for (int i = 0; i < 20; i++) doTick("R4");
    spreadOffN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      doTick("R4");
      check(int'(offset) == 0, "R4", int'(offset), 0);
    end
  endtask

  task automatic testReenable();
    startSweep(1'b0, 6, 0);
    doTick("R5");
    check(int'(offset) == 0, "R5", int'(offset), 0);
    doTick("R5");
    check(offset > 0, "R5", int'(offset), 1);
    startSweep(1'b1, 6, 0);
    doTick("R5");
    check(int'(offset) == 0, "R5", int'(offset), 0);
    doTick("R5");
    check(offset < 0, "R5", int'(offset), -1);
  endtask

  task automatic testHold();
    int held;
    startSweep(1'b0, 11, 0);
    for (int i = 0; i < 5; i++) doTick("R8");
    held = int'(offset);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(offsetValid === 1'b0, "R8", int'(offsetValid), 0);
      check(int'(offset) == held, "R8", int'(offset), held);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testCenter();
    testDown();
    testRates();
    testSaturate();
    testLatch();
    testDisable();
    testReenable();
    testHold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule